// File: doc/BRIEF.md
# Masked Vector Float-to-Integer Converter

This block converts a packed vector of IEEE-754 single-precision values into 32-bit integers, one conversion per lane, all lanes in parallel. A mode input picks a signed or an unsigned result. An execute mask picks which lanes are written. Lanes whose mask bit is clear keep the value they held before.

Each lane rounds by truncation toward zero. NaN, infinities and large magnitudes are handled apart from that rule. A NaN gives zero. Large magnitudes and infinities saturate, and the saturation starts at fixed thresholds: 2^30 in signed mode and 2^31 in unsigned mode. These are not the true representable limits.

Results are registered. They appear one clock after the valid strobe, and the result-valid flag marks that cycle.

Top module: `fcvt_vec`

## Requirements
- R1: Lane i takes its input from `in_data[32*i+31:32*i]` and writes its result to `out_data[32*i+31:32*i]`. The lane is written only when `in_valid` is high and `in_mask[i]` is 1.
- R2: A lane whose mask bit is 0 keeps its previous output value. When `in_valid` is low, no lane changes.
- R3: A NaN input (exponent field 255, nonzero fraction) gives 0 in both modes.
- R4: When `in_mode`=0 (signed), an infinity or a finite value with magnitude of at least 2^30 saturates by its sign bit. A negative value gives 0x80000000 and a positive value gives 0x7FFFFFFF.
- R5: When `in_mode`=1 (unsigned), +infinity and any positive finite value of at least 2^31 give 0xFFFFFFFF.
- R6: When `in_mode`=1, −infinity and every negative finite value give 0.
- R7: In signed mode, any other finite value is truncated toward zero and returned in two's complement. For example, −2.5 gives −2, and 2^30−64 gives 1073741760.
- R8: In unsigned mode, any other positive finite value is truncated toward zero. For example, 2^31−128 gives 2147483520.
- R9: Zero, negative zero, denormals and any value with magnitude below 1.0 give 0 in both modes.
- R10: `out_valid` is high in the cycle after each cycle in which `in_valid` was high, and low otherwise. Output data for a strobe is visible in that same cycle.
- R11: A synchronous active-high `rst` clears every output lane to 0 and drives `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe; one conversion per high cycle |
| in_mode | input | 1 | 0 = signed result, 1 = unsigned result |
| in_mask | input | LANES | Per-lane write enable |
| in_data | input | 32*LANES | Packed single-precision lane values |
| out_valid | output | 1 | High for one cycle after each strobe |
| out_data | output | 32*LANES | Packed 32-bit integer results |

## Verification
The bench sends values on both sides of each saturation threshold: just below and at 2^30, and just below and at 2^31. A design that used the true integer limits, or compared the exponent off by one, would pass through or clamp the wrong neighbour.

It sends NaN in both modes. A design that treated NaN as an infinity would return a saturated value instead of zero.

It sends negative infinity and small negative values in unsigned mode. A design that dropped the sign would return the magnitude rather than zero.

It also checks negative zero, denormals and fractions, and it holds some lanes masked across several strobes. A design that wrote masked lanes would show a changed value on those lanes.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    localparam int unsigned FP_W      = 32;
    localparam int unsigned EXP_W     = 8;
    localparam int unsigned FRAC_W    = 23;
    localparam logic [7:0]  EXP_BIAS  = 8'd127;
    localparam logic [7:0]  EXP_SAT_S = 8'd157;  // 2^30
    localparam logic [7:0]  EXP_SAT_U = 8'd158;  // 2^31
    localparam logic [7:0]  EXP_SPEC  = 8'd255;

    localparam logic [31:0] INT_POS_SAT = 32'h7FFF_FFFF;
    localparam logic [31:0] INT_NEG_SAT = 32'h8000_0000;
    localparam logic [31:0] UNS_SAT     = 32'hFFFF_FFFF;

    typedef enum logic {
        MODE_S32 = 1'b0,
        MODE_U32 = 1'b1
    } cvt_mode_e;

    typedef enum logic [1:0] {
        CLS_TINY   = 2'd0,   // zero or denormal
        CLS_NORMAL = 2'd1,
        CLS_INF    = 2'd2,
        CLS_NAN    = 2'd3
    } fp_class_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_fields_t;

    function automatic fp_fields_t split_fp(input logic [FP_W-1:0] bits);
        fp_fields_t f;
        f.sign = bits[31];
        f.exp  = bits[30:23];
        f.frac = bits[22:0];
        return f;
    endfunction

endpackage

// File: rtl/fcvt_classify.sv
module fcvt_classify
    import fcvt_pkg::*;
(
    input  fp_fields_t fields_i,
    output fp_class_e  class_o
);
    always_comb begin
        if (fields_i.exp == EXP_SPEC) begin
            class_o = (fields_i.frac != '0) ? CLS_NAN : CLS_INF;
        end else if (fields_i.exp == '0) begin
            class_o = CLS_TINY;
        end else begin
            class_o = CLS_NORMAL;
        end
    end
endmodule

// File: rtl/fcvt_mag.sv
module fcvt_mag
    import fcvt_pkg::*;
(
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [31:0]       mag_o
);
    // Integer part of 1.frac * 2^(exp-127), for exponents 127..157
    localparam int unsigned WIDE_W = 56;

    logic [4:0]        sh;
    logic              in_range;
    logic [WIDE_W-1:0] wide;

    always_comb begin
        in_range = (exp_i >= EXP_BIAS) && (exp_i <= EXP_SAT_S);
        sh       = in_range ? 5'(exp_i - EXP_BIAS) : 5'd0;
        wide     = {{(WIDE_W-FRAC_W-1){1'b0}}, 1'b1, frac_i} << sh;
        mag_o    = in_range ? wide[FRAC_W +: 32] : 32'd0;
    end
endmodule

// File: rtl/fcvt_lane.sv
module fcvt_lane
    import fcvt_pkg::*;
(
    input  logic [FP_W-1:0] bits_i,
    input  cvt_mode_e       mode_i,
    output logic [31:0]     res_o
);
    fp_fields_t  f;
    fp_class_e   cls;
    logic [31:0] mag;

    assign f = split_fp(bits_i);

    fcvt_classify u_cls (
        .fields_i (f),
        .class_o  (cls)
    );

    fcvt_mag u_mag (
        .exp_i  (f.exp),
        .frac_i (f.frac),
        .mag_o  (mag)
    );

    always_comb begin
        res_o = 32'd0;
        unique case (cls)
            CLS_NAN, CLS_TINY: res_o = 32'd0;
            CLS_INF: begin
                if (mode_i == MODE_S32) res_o = f.sign ? INT_NEG_SAT : INT_POS_SAT;
                else                    res_o = f.sign ? 32'd0 : UNS_SAT;
            end
            CLS_NORMAL: begin
                if (mode_i == MODE_S32) begin
                    if (f.exp >= EXP_SAT_S) res_o = f.sign ? INT_NEG_SAT : INT_POS_SAT;
                    else                    res_o = f.sign ? (32'd0 - mag) : mag;
                end else begin
                    if (f.sign)                  res_o = 32'd0;
                    else if (f.exp >= EXP_SAT_U) res_o = UNS_SAT;
                    else                         res_o = mag;
                end
            end
            default: res_o = 32'd0;
        endcase
    end
endmodule

// File: rtl/fcvt_vec.sv
module fcvt_vec
    import fcvt_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  in_mode,
    input  logic [LANES-1:0]      in_mask,
    input  logic [LANES*FP_W-1:0] in_data,
    output logic                  out_valid,
    output logic [LANES*32-1:0]   out_data
);
    localparam int unsigned OUT_W = 32;

    cvt_mode_e              mode;
    logic [LANES*OUT_W-1:0] conv;
    logic [LANES*OUT_W-1:0] dst_q;
    logic                   vld_q;

    assign mode = cvt_mode_e'(in_mode);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fcvt_lane u_lane (
            .bits_i (in_data[g*FP_W +: FP_W]),
            .mode_i (mode),
            .res_o  (conv[g*OUT_W +: OUT_W])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                dst_q[g*OUT_W +: OUT_W] <= '0;
            end else if (in_valid && in_mask[g]) begin
                dst_q[g*OUT_W +: OUT_W] <= conv[g*OUT_W +: OUT_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= in_valid;
    end

    assign out_valid = vld_q;
    assign out_data  = dst_q;
endmodule

// File: rtl/fcvt_vec_chk.sv
module fcvt_vec_chk #(
    parameter int unsigned LANES = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_mode,
    input logic [LANES-1:0]    in_mask,
    input logic [LANES*32-1:0] in_data,
    input logic                out_valid,
    input logic [LANES*32-1:0] out_data
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0)); // R11

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R10

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data))); // R2

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !in_mask[g]) |=> $stable(out_data[g*32 +: 32])); // R2

        AST_NAN_ZERO: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_mask[g] && in_data[g*32+23 +: 8] == 8'hFF
             && in_data[g*32 +: 23] != '0) |=> (out_data[g*32 +: 32] == 32'd0)); // R3

        AST_UNS_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_mask[g] && in_mode && in_data[g*32+31])
            |=> (out_data[g*32 +: 32] == 32'd0)); // R6

        AST_SGN_SAT_POS: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_mask[g] && !in_mode && !in_data[g*32+31]
             && in_data[g*32+23 +: 8] >= 8'd157 && in_data[g*32 +: 31] <= 31'h7F80_0000)
            |=> (out_data[g*32 +: 32] == 32'h7FFF_FFFF)); // R4
    end
endmodule

bind fcvt_vec fcvt_vec_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_mask   (in_mask),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_fcvt_vec.sv
module tb_fcvt_vec;
    localparam int LANES = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic                in_mode = 1'b0;
    logic [LANES-1:0]    in_mask = '0;
    logic [LANES*32-1:0] in_data = '0;
    logic                out_valid;
    logic [LANES*32-1:0] out_data;

    int checks = 0;
    int failures = 0;

    logic [31:0] exp_lane [LANES];
    logic        exp_valid;

    always #5 clk = ~clk;

    fcvt_vec #(.LANES(LANES)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_mask(in_mask), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [31:0] ref_conv(input logic [31:0] x, input bit uns);
        int  e = int'(x[30:23]);
        int  f = int'(x[22:0]);
        real v;
        if (e == 255 && f != 0) return 32'd0;
        if (e == 255) begin
            if (uns) return x[31] ? 32'd0 : 32'hFFFF_FFFF;
            return x[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
        end
        if (e == 0) return 32'd0;
        v = (1.0 + f / 8388608.0) * (2.0 ** (e - 127));
        if (!uns) begin
            if (v >= 1073741824.0) return x[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
            return x[31] ? -$rtoi(v) : $rtoi(v);
        end
        if (x[31]) return 32'd0;
        if (v >= 2147483648.0) return 32'hFFFF_FFFF;
        return 32'($rtoi(v));
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (out_valid !== exp_valid) begin
            failures++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", tag, out_valid, exp_valid);
        end
        for (int i = 0; i < LANES; i++) begin
            checks++;
            if (out_data[i*32 +: 32] !== exp_lane[i]) begin
                failures++;
                $display("FAIL %s lane%0d actual=%h expected=%h",
                         tag, i, out_data[i*32 +: 32], exp_lane[i]);
            end
        end
    endtask

    // Drive one cycle of stimulus at the falling edge, update the model, check after the edge.
    task automatic apply(input bit v, input bit uns, input logic [LANES-1:0] m,
                         input logic [31:0] a0, input logic [31:0] a1,
                         input logic [31:0] a2, input logic [31:0] a3, input string tag);
        logic [31:0] a [LANES];
        a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
        in_valid = v; in_mode = uns; in_mask = m;
        for (int i = 0; i < LANES; i++) in_data[i*32 +: 32] = a[i];
        if (v) begin
            for (int i = 0; i < LANES; i++)
                if (m[i]) exp_lane[i] = ref_conv(a[i], uns);
        end
        exp_valid = v;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < LANES; i++) exp_lane[i] = 32'd0;
        exp_valid = 1'b0;
        in_data = {LANES{32'h3F80_0000}};
        in_valid = 1'b1; in_mask = '1;
        repeat (3) @(negedge clk);
        compare("R11 reset");
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        compare("R11 idle after reset");

        // signed truncation R7 and latency R10
        apply(1, 0, 4'hF, 32'h3F80_0000, 32'hC020_0000, 32'h4020_0000, 32'h47F1_2036, "R7 R10 signed trunc");
        apply(0, 0, 4'hF, 32'h7FC0_0000, 32'h7FC0_0000, 32'h7FC0_0000, 32'h7FC0_0000, "R2 R10 no strobe");
        // NaN both modes R3
        apply(1, 0, 4'h3, 32'h7FC0_0000, 32'hFFC0_0001, 32'h0, 32'h0, "R3 R2 nan signed, masked upper");
        apply(1, 1, 4'hC, 32'h0, 32'h0, 32'h7F80_0001, 32'hFFFF_FFFF, "R3 nan unsigned");
        // signed saturation R4
        apply(1, 0, 4'hF, 32'h7F80_0000, 32'hFF80_0000, 32'h4E80_0000, 32'hCE80_0000, "R4 signed sat");
        apply(1, 0, 4'hF, 32'h4E7F_FFFF, 32'hCE7F_FFFF, 32'h4F00_0000, 32'h5F00_0000, "R4 R7 signed threshold");
        // unsigned saturation R5
        apply(1, 1, 4'hF, 32'h7F80_0000, 32'h4F00_0000, 32'h4EFF_FFFF, 32'h4E80_0000, "R5 R8 unsigned threshold");
        // unsigned negative R6
        apply(1, 1, 4'hF, 32'hFF80_0000, 32'hBF80_0000, 32'hCF00_0000, 32'hBF40_0000, "R6 unsigned neg");
        // tiny values R9
        apply(1, 0, 4'hF, 32'h8000_0000, 32'h0000_0001, 32'h3F40_0000, 32'hBF7F_FFFF, "R9 tiny signed");
        apply(1, 1, 4'hF, 32'h8000_0000, 32'h807F_FFFF, 32'h3F7F_FFFF, 32'h0000_0000, "R9 tiny unsigned");
        // masking R1 R2
        apply(1, 1, 4'h5, 32'h4020_0000, 32'h4F00_0000, 32'h4B00_0001, 32'h7F80_0000, "R1 R2 mask 0101");
        apply(1, 0, 4'h0, 32'h7F80_0000, 32'h7F80_0000, 32'h7F80_0000, 32'h7F80_0000, "R2 empty mask");
        apply(1, 0, 4'h8, 32'h0, 32'h0, 32'h0, 32'hC2F6_E979, "R1 R7 single lane");
        apply(1, 1, 4'hF, 32'h4B80_0001, 32'h4D80_0003, 32'h3FFF_FFFF, 32'h4E00_0007, "R8 unsigned trunc");
        apply(0, 0, 4'hF, 32'h0, 32'h0, 32'h0, 32'h0, "R10 idle");
        apply(0, 1, 4'hF, 32'h0, 32'h0, 32'h0, 32'h0, "R10 idle 2");

        // reset mid-run R11
        rst = 1'b1;
        for (int i = 0; i < LANES; i++) exp_lane[i] = 32'd0;
        exp_valid = 1'b0;
        @(negedge clk);
        compare("R11 reset mid-run");
        rst = 1'b0;
        apply(1, 0, 4'hF, 32'hC780_0000, 32'h4B7F_FFFF, 32'h3FC0_0000, 32'hBFC0_0000, "R7 post reset");
        apply(0, 0, 4'h0, 32'h0, 32'h0, 32'h0, 32'h0, "R10 final idle");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule